// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects interrupt request lines from the peripherals of a small CPU and turns them into one vectored grant at a time. Twenty request sources share ten vectors. Each source has its own enable bit. Each vector has a priority level that software writes through a small write port. The three levels are low, high and top. Only the two lowest-numbered vectors may be raised to the top level.

When at least one vector is eligible, the controller registers the winner and presents its fixed entry address. The address is held until the CPU acknowledges. On acknowledge, the winner's level is recorded in an in-service stack that has one bit per level. Until the matching return strobe removes that level, requests of the same or a lower level stay pending. Requests of a strictly higher level still get through, so service routines can nest up to three deep.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, no grant is presented, `irq_addr` reads 0, `isr_level` reads 0 (nothing in service), and every vector is at level low.
- R2: The address presented for vector v is 3 + 8·v, which gives 0x03 for vector 0 and 0x4B for vector 9.
- R3: Source s belongs to vector s mod 10. A vector requests only if at least one of its sources has both its request bit and its enable bit set.
- R4: Among eligible vectors, the one at the highest level wins. Level codes on `lvl_val` are 0 = low, 1 = high, 2 = top.
- R5: Among eligible vectors at the same level, the vector with the lower index (lower address) wins.
- R6: Level top is accepted only for vectors 0 and 1. A write of code 2 (top) or code 3 to any other vector is ignored, and that vector keeps its previous level.
- R7: A vector is eligible only if its level is strictly above the highest level in service. A blocked request stays pending and is granted once the in-service level drops below it.
- R8: A grant appears on the clock edge after its request becomes eligible. Its address stays stable until `ack`, even if a higher-level request arrives in the meantime.
- R9: `ack` during a grant ends the grant and pushes the granted level. `isr_level` reports the highest level in service (0 none, 1 low, 2 high, 3 top).
- R10: `reti` clears the highest level in service. A `reti` with nothing in service has no effect.
- R11: When `ack` and `reti` arrive in the same cycle, the return first removes the old top level, and then the granted level is pushed.
- R12: `ack` while no grant is presented is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 20 | Request line of each source |
| src_en | input | 20 | Enable bit of each source |
| lvl_we | input | 1 | Level write strobe |
| lvl_sel | input | 4 | Vector whose level is written |
| lvl_val | input | 2 | Level code to write |
| ack | input | 1 | CPU accepts the presented grant |
| reti | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | A grant is presented |
| irq_addr | output | 16 | Entry address of the granted vector |
| isr_level | output | 2 | Highest level in service |

## Verification
Two functions can fall in the same clock cycle: the acknowledge that pushes a new level and the return that pops the current top level. The bench provokes this by first nesting a high-level grant above an active low-level handler, then driving `ack` and `reti` together on one edge. The result passes only if `isr_level` then shows exactly the high level, which means the low level was removed before the new level was recorded. The other case that shares a cycle is a higher-level request arriving while an older grant waits for acknowledge. It is judged by the address staying put until `ack`.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   typedef enum logic [1:0] {
      LV_LOW  = 2'd0,
      LV_HIGH = 2'd1,
      LV_TOP  = 2'd2,
      LV_RSVD = 2'd3
   } irq_lvl_e;

   // home vector of a request source
   function automatic int unsigned src_home(input int unsigned s, input int unsigned nvec);
      return s % nvec;
   endfunction

   // rank: 0 = nothing, level code + 1 otherwise
   function automatic logic [2:0] lvl_rank(input logic [1:0] code);
      return {1'b0, code} + 3'd1;
   endfunction
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
   import irq_vec_pkg::*;
#(
   parameter int N_VEC = 10,
   parameter int N_TOP = 2,
   parameter int VEC_W = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [VEC_W-1:0]        sel,
   input  logic [1:0]              val,
   output logic [N_VEC-1:0][1:0]   lvl_q
);
   if (N_TOP > N_VEC) begin : g_bad_top
      $error("irq_lvl_regs: N_TOP exceeds N_VEC");
   end

   for (genvar v = 0; v < N_VEC; v++) begin : g_vec
      localparam bit CAN_TOP = (v < N_TOP);
      logic code_ok;
      logic hit;

      if (CAN_TOP) begin : g_top_ok
         assign code_ok = (val == LV_LOW) || (val == LV_HIGH) || (val == LV_TOP);
      end else begin : g_top_no
         assign code_ok = (val == LV_LOW) || (val == LV_HIGH);
      end

      assign hit = we && (sel == VEC_W'(v)) && code_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   lvl_q[v] <= LV_LOW;
         else if (hit) lvl_q[v] <= val;
      end

      if (!CAN_TOP) begin : g_chk
         assert_top_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == VEC_W'(v) && (val == LV_TOP || val == LV_RSVD)) |=> $stable(lvl_q[v]));
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_vec_pkg::*;
#(
   parameter int N_SRC = 20,
   parameter int N_VEC = 10,
   parameter int VEC_W = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        src_req,
   input  logic [N_SRC-1:0]        src_en,
   input  logic [N_VEC-1:0][1:0]   lvl,
   input  logic [1:0]              cur_rank,
   output logic                    any_win,
   output logic [VEC_W-1:0]        win_idx,
   output logic [1:0]              win_rank
);
   logic [N_VEC-1:0] pend;
   logic [N_VEC-1:0] elig;
   logic [2:0]       best;

   always_comb begin
      pend = '0;
      for (int s = 0; s < N_SRC; s++) begin
         pend[src_home(s, N_VEC)] = pend[src_home(s, N_VEC)] | (src_req[s] & src_en[s]);
      end
   end

   always_comb begin
      for (int v = 0; v < N_VEC; v++) begin
         elig[v] = pend[v] && (lvl_rank(lvl[v]) > {1'b0, cur_rank});
      end
   end

   // strict compare in ascending order keeps the lowest index on ties
   always_comb begin
      best    = 3'd0;
      win_idx = '0;
      for (int v = 0; v < N_VEC; v++) begin
         if (elig[v] && lvl_rank(lvl[v]) > best) begin
            best    = lvl_rank(lvl[v]);
            win_idx = VEC_W'(v);
         end
      end
      any_win  = |elig;
      win_rank = best[1:0];
   end

   assert_win_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
      any_win |-> ({1'b0, win_rank} > {1'b0, cur_rank}));
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
   parameter int N_LVL = 3,
   parameter int RK_W  = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [RK_W-1:0] push_rank,
   input  logic            pop,
   output logic [RK_W-1:0] cur_rank
);
   if ((1 << RK_W) < N_LVL + 1) begin : g_bad_rk
      $error("irq_nest_stack: RK_W too narrow for N_LVL");
   end

   logic [N_LVL-1:0] ins_q;
   logic [N_LVL-1:0] ins_n;
   logic [N_LVL-1:0] top_hot;
   logic [N_LVL-1:0] push_hot;

   always_comb begin
      top_hot  = '0;
      cur_rank = '0;
      for (int i = 0; i < N_LVL; i++) begin
         if (ins_q[i]) begin
            top_hot    = '0;
            top_hot[i] = 1'b1;
            cur_rank   = RK_W'(i + 1);
         end
      end
   end

   always_comb begin
      push_hot = '0;
      for (int i = 0; i < N_LVL; i++) begin
         if (push && push_rank == RK_W'(i + 1)) push_hot[i] = 1'b1;
      end
      ins_n = (pop ? (ins_q & ~top_hot) : ins_q) | push_hot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ins_q <= '0;
      else        ins_q <= ins_n;
   end

   assert_pop_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && ins_q != '0) |=> ($countones(ins_q) == $countones($past(ins_q)) - 1));
   assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && ins_q == '0) |=> (ins_q == '0));
   assert_push_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (cur_rank >= $past(push_rank)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_vec_pkg::*;
#(
   parameter int N_SRC  = 20,
   parameter int N_VEC  = 10,
   parameter int N_TOP  = 2,
   parameter int ADDR_W = 16,
   parameter int BASE   = 3,
   parameter int STRIDE = 8,
   localparam int VEC_W = (N_VEC > 1) ? $clog2(N_VEC) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic [N_SRC-1:0]  src_en,
   input  logic              lvl_we,
   input  logic [VEC_W-1:0]  lvl_sel,
   input  logic [1:0]        lvl_val,
   input  logic              ack,
   input  logic              reti,
   output logic              irq_valid,
   output logic [ADDR_W-1:0] irq_addr,
   output logic [1:0]        isr_level
);
   localparam longint LAST_ADDR = longint'(BASE) + longint'(STRIDE) * longint'(N_VEC - 1);

   if (N_SRC < N_VEC) begin : g_bad_src
      $error("irq_vec_ctrl: fewer sources than vectors");
   end
   if (LAST_ADDR >= (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("irq_vec_ctrl: vector addresses do not fit ADDR_W");
   end

   logic [N_VEC-1:0][1:0] lvl;
   logic                  any_win;
   logic [VEC_W-1:0]      win_idx;
   logic [1:0]            win_rank;
   logic [1:0]            cur_rank;

   logic                  gnt_v;
   logic [VEC_W-1:0]      gnt_idx;
   logic [1:0]            gnt_rank;
   logic                  take;

   irq_lvl_regs #(.N_VEC(N_VEC), .N_TOP(N_TOP), .VEC_W(VEC_W)) u_lvl (
      .clk(clk), .rst_n(rst_n), .we(lvl_we), .sel(lvl_sel), .val(lvl_val), .lvl_q(lvl)
   );

   irq_arbiter #(.N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_W(VEC_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en), .lvl(lvl),
      .cur_rank(cur_rank), .any_win(any_win), .win_idx(win_idx), .win_rank(win_rank)
   );

   assign take = gnt_v && ack;

   irq_nest_stack #(.N_LVL(3), .RK_W(2)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(take), .push_rank(gnt_rank), .pop(reti),
      .cur_rank(cur_rank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_v    <= 1'b0;
         gnt_idx  <= '0;
         gnt_rank <= '0;
      end else if (gnt_v) begin
         if (ack) gnt_v <= 1'b0;
      end else if (any_win) begin
         gnt_v    <= 1'b1;
         gnt_idx  <= win_idx;
         gnt_rank <= win_rank;
      end
   end

   assign irq_valid = gnt_v;
   assign irq_addr  = gnt_v ? ADDR_W'(BASE + STRIDE * int'(gnt_idx)) : '0;
   assign isr_level = cur_rank;

   assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !ack) |=> (irq_valid && $stable(irq_addr)));
   assert_grant_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ({1'b0, gnt_rank} > {1'b0, isr_level}));
   assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_valid && ack && !reti) |=> $stable(isr_level));
   assert_ack_reti_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && ack && reti) |=> (isr_level == $past(gnt_rank)));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] req = '0;
   logic [19:0] en = '1;
   logic        we = 1'b0;
   logic [3:0]  sel = '0;
   logic [1:0]  val = '0;
   logic        ack = 1'b0;
   logic        reti = 1'b0;
   logic        irq_valid;
   logic [15:0] irq_addr;
   logic [1:0]  isr_level;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   irq_vec_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_req(req), .src_en(en), .lvl_we(we),
      .lvl_sel(sel), .lvl_val(val), .ack(ack), .reti(reti),
      .irq_valid(irq_valid), .irq_addr(irq_addr), .isr_level(isr_level)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_lvl(input int v, input int l);
      we = 1'b1; sel = 4'(v); val = 2'(l);
      tick();
      we = 1'b0;
      tick();
   endtask

   // acknowledge the presented grant, dropping all requests
   task automatic take_all(input string tag, input int lvl_after);
      ack = 1'b1; req = '0;
      tick();
      ack = 1'b0;
      chk(tag, isr_level, lvl_after);
   endtask

   task automatic ret(input string tag, input int lvl_after);
      reti = 1'b1;
      tick();
      reti = 1'b0;
      chk(tag, isr_level, lvl_after);
   endtask

   task automatic t_reset();
      chk("R1 valid", irq_valid, 0);
      chk("R1 addr", irq_addr, 0);
      chk("R1 level", isr_level, 0);
   endtask

   task automatic t_addr();
      for (int v = 0; v < 10; v++) begin
         req = '0; req[v] = 1'b1;
         tick();
         chk("R2 valid", irq_valid, 1);
         chk("R2 addr", irq_addr, 3 + 8 * v);
         take_all("R9 push low", 1);
         ret("R10 pop", 0);
      end
   endtask

   task automatic t_enable();
      en = '0; en[3] = 1'b1;
      req[13] = 1'b1;
      tick(); tick();
      chk("R3 masked", irq_valid, 0);
      en[13] = 1'b1;
      tick();
      chk("R3 valid", irq_valid, 1);
      chk("R3 addr", irq_addr, 27);
      take_all("R3 push", 1);
      ret("R3 pop", 0);
      en = '1;
   endtask

   task automatic t_level();
      set_lvl(7, 1);
      req[2] = 1'b1; req[7] = 1'b1;
      tick();
      chk("R4 addr", irq_addr, 59);
      take_all("R4 push high", 2);
      ret("R4 pop", 0);
   endtask

   task automatic t_tie();
      req[15] = 1'b1; req[4] = 1'b1;
      tick();
      chk("R5 addr", irq_addr, 35);
      take_all("R5 push", 1);
      ret("R5 pop", 0);
   endtask

   task automatic t_xlimit();
      set_lvl(3, 1);
      set_lvl(3, 2);
      set_lvl(3, 3);
      set_lvl(0, 2);
      req[3] = 1'b1; req[0] = 1'b1; req[1] = 1'b1;
      tick();
      chk("R6 top on v0", irq_addr, 3);
      take_all("R6 push top", 3);
      ret("R6 pop", 0);
      req[7] = 1'b1;
      tick();
      chk("R6 high grant", irq_addr, 59);
      take_all("R6 push high", 2);
      req[3] = 1'b1;
      tick(); tick();
      chk("R6 v3 kept high", irq_valid, 0);
      req = '0;
      ret("R6 pop high", 0);
   endtask

   task automatic t_nest();
      req[2] = 1'b1;
      tick();
      chk("R7 low grant", irq_addr, 19);
      take_all("R7 push low", 1);
      req[1] = 1'b1;
      tick(); tick();
      chk("R7 equal blocked", irq_valid, 0);
      req[7] = 1'b1;
      tick();
      chk("R7 high preempts", irq_addr, 59);
      ack = 1'b1; req[7] = 1'b0;
      tick();
      ack = 1'b0;
      chk("R9 push high", isr_level, 2);
      req[0] = 1'b1;
      tick();
      chk("R7 top preempts", irq_addr, 3);
      ack = 1'b1; req[0] = 1'b0;
      tick();
      ack = 1'b0;
      chk("R9 push top", isr_level, 3);
      ret("R10 pop top", 2);
      ret("R10 pop high", 1);
      chk("R7 still blocked", irq_valid, 0);
      ret("R10 pop low", 0);
      tick();
      chk("R7 pending granted", irq_valid, 1);
      chk("R7 pending addr", irq_addr, 11);
      take_all("R7 push", 1);
      ret("R7 pop", 0);
   endtask

   task automatic t_hold();
      req[2] = 1'b1;
      tick();
      chk("R8 first", irq_addr, 19);
      req[0] = 1'b1;
      tick(); tick();
      chk("R8 valid held", irq_valid, 1);
      chk("R8 addr held", irq_addr, 19);
      ack = 1'b1; req[2] = 1'b0;
      tick();
      ack = 1'b0;
      chk("R8 push", isr_level, 1);
      tick();
      chk("R8 next addr", irq_addr, 3);
      take_all("R8 push top", 3);
      reti = 1'b1;
      tick(); tick();
      reti = 1'b0;
      chk("R8 drained", isr_level, 0);
   endtask

   task automatic t_same();
      req[2] = 1'b1;
      tick();
      take_all("R11 push low", 1);
      req[7] = 1'b1;
      tick();
      chk("R11 grant", irq_addr, 59);
      ack = 1'b1; reti = 1'b1; req = '0;
      tick();
      ack = 1'b0; reti = 1'b0;
      chk("R11 level", isr_level, 2);
      ret("R11 pop", 0);
   endtask

   task automatic t_stray();
      ack = 1'b1;
      tick();
      ack = 1'b0;
      chk("R12 level", isr_level, 0);
      chk("R12 valid", irq_valid, 0);
      ret("R10 empty pop", 0);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_addr();
      t_enable();
      t_level();
      t_tie();
      t_xlimit();
      t_nest();
      t_hold();
      t_same();
      t_stray();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule